// File: doc/BRIEF.md
# Absolute Position Encoder Serial Responder

This block plays the sensor side of a clocked, unidirectional position link. A master idles its clock line high and starts a request by pulling it low and toggling it. The responder watches that line, answers with a fixed-format frame on its single data output, and then stays busy for a set time before it accepts another request. It is synthesizable and meant to sit opposite a master controller in loopback tests, so that the master's acknowledge search, field decode and checksum logic can run against real hardware behaviour.

The clock line from the master is asynchronous to the system clock. It passes through a two-stage synchronizer and an edge detector, so every reaction on the data output happens three system clocks after the matching master edge. The position word and the two status flags are copied into a shadow frame when the request begins. That copy includes the computed checksum, so changes at the inputs during the transfer never reach the line.

Top module: `enc_responder`

## Requirements
- R1: After reset, and whenever no request is in progress and the busy time has passed, `slo_o` is high.
- R2: The first falling edge of `ma_i` while idle opens a request. The first rising edge that follows leaves `slo_o` high, and the second rising edge drives `slo_o` low as the acknowledge.
- R3: The acknowledge lasts ACK_LEN master clock periods. The next rising edge sends a start bit of 1, and the edge after that sends a bit of 0.
- R4: Next, one bit per rising edge, come the POS_W position bits with the most significant bit first, then the error flag, then the warning flag. Both flags are sent exactly as given at the active-low inputs.
- R5: Next come 6 checksum bits, most significant first and each one inverted. The checksum is the remainder of the position bits followed by the error and warning bits, divided by x^6 + x + 1, with the register starting at zero. The start bit and the zero bit are not part of the checksum.
- R6: The rising edge after the last checksum bit drives `slo_o` low. It stays low for BUSY_CYC+1 system clocks and then returns high.
- R7: Position, error and warning are sampled on the falling edge that opens the request. Changes to them later in that request do not alter the frame.
- R8: If `ma_i` stays high for TOUT_CYC system clocks during a request, the request is aborted and the responder enters the busy period with `slo_o` low.
- R9: Edges on `ma_i` during the busy period are ignored and do not open a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ma_i | input | 1 | Clock line from the master, high when idle |
| pos_i | input | POS_W | Position word to report |
| err_n_i | input | 1 | Error flag, active low |
| warn_n_i | input | 1 | Warning flag, active low |
| slo_o | output | 1 | Serial data line back to the master |

## Verification
The assertions assume that every level on `ma_i` lasts at least three system clocks, so that each rise and fall appears as one clean event after the synchronizer. They also assume that the master's normal high half-period is well below TOUT_CYC, so a timeout only happens when the master really stops. The stimulus holds each half-period of `ma_i` for four system clocks and reads `slo_o` at the end of the low half, which is well after the three-clock reaction time. Only the deliberate abort and the end of each frame hold the line high for longer.

// File: rtl/enc_resp_pkg.sv
package enc_resp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ACK,
    ST_DATA,
    ST_BUSY
  } resp_st_e;

  localparam int CRC_W = 6;
  // x^6 + x + 1 without the implicit top term
  localparam logic [CRC_W-1:0] CRC_POLY = 6'h03;

  // One serial step of the checksum register, MSB-first feed.
  function automatic logic [CRC_W-1:0] crc6_next(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/enc_ma_edge.sv
module enc_ma_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ma_i,
  output logic ma_hi,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= ma_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign ma_hi = s2;
  assign rise  = s2 & ~s3;
  assign fall  = ~s2 & s3;
endmodule

// File: rtl/enc_frame_pack.sv
module enc_frame_pack
  import enc_resp_pkg::*;
#(
  parameter int POS_W = 18
) (
  input  logic [POS_W-1:0]         pos,
  input  logic                     err_n,
  input  logic                     warn_n,
  output logic [POS_W+3+CRC_W:0]   frame
);
  logic [CRC_W-1:0] crc;

  always_comb begin
    crc = '0;
    for (int i = POS_W - 1; i >= 0; i--) begin
      crc = crc6_next(crc, pos[i]);
    end
    crc = crc6_next(crc, err_n);
    crc = crc6_next(crc, warn_n);
    frame = {1'b1, 1'b0, pos, err_n, warn_n, ~crc};
  end
endmodule

// File: rtl/enc_hold_cnt.sv
module enc_hold_cnt #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (!hit) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == LAST);
endmodule

// File: rtl/enc_responder.sv
module enc_responder
  import enc_resp_pkg::*;
#(
  parameter int POS_W    = 18,
  parameter int ACK_LEN  = 2,
  parameter int BUSY_CYC = 100,
  parameter int TOUT_CYC = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ma_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             err_n_i,
  input  logic             warn_n_i,
  output logic             slo_o
);
  localparam int FR_W     = POS_W + 4 + CRC_W;
  localparam int STEP_MAX = (FR_W > ACK_LEN) ? FR_W : ACK_LEN;
  localparam int SW       = $clog2(STEP_MAX + 1);
  localparam logic [SW-1:0] ONE      = SW'(1);
  localparam logic [SW-1:0] ACK_LAST = SW'(ACK_LEN);
  localparam logic [SW-1:0] FR_LAST  = SW'(FR_W);

  resp_st_e        st;
  logic [SW-1:0]   step;
  logic [FR_W-1:0] shadow;
  logic [FR_W-1:0] frame_now;
  logic            ma_hi, ma_rise, ma_fall;
  logic            tout_hit, busy_hit;

  // named events, shared with the checker
  logic active, req_start, ack_go, ack_done, frame_end, abort;
  assign active    = (st == ST_REQ) || (st == ST_ACK) || (st == ST_DATA);
  assign abort     = active && tout_hit;
  assign req_start = (st == ST_IDLE) && ma_fall;
  assign ack_go    = (st == ST_REQ)  && ma_rise && !abort && (step == ONE);
  assign ack_done  = (st == ST_ACK)  && ma_rise && !abort && (step == ACK_LAST);
  assign frame_end = (st == ST_DATA) && ma_rise && !abort && (step == FR_LAST);

  enc_ma_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .ma_i  (ma_i),
    .ma_hi (ma_hi),
    .rise  (ma_rise),
    .fall  (ma_fall)
  );

  enc_frame_pack #(.POS_W(POS_W)) u_pack (
    .pos    (pos_i),
    .err_n  (err_n_i),
    .warn_n (warn_n_i),
    .frame  (frame_now)
  );

  enc_hold_cnt #(.LIMIT(TOUT_CYC)) u_tout (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!(active && ma_hi)),
    .hit   (tout_hit)
  );

  enc_hold_cnt #(.LIMIT(BUSY_CYC)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st != ST_BUSY),
    .hit   (busy_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      slo_o  <= 1'b1;
      step   <= '0;
      shadow <= '0;
    end else if (abort) begin
      st    <= ST_BUSY;
      slo_o <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_start) begin
            st     <= ST_REQ;
            shadow <= frame_now;
            step   <= '0;
          end
        end
        ST_REQ: begin
          if (ack_go) begin
            st    <= ST_ACK;
            slo_o <= 1'b0;
            step  <= ONE;
          end else if (ma_rise) begin
            step <= ONE;
          end
        end
        ST_ACK: begin
          if (ack_done) begin
            st     <= ST_DATA;
            slo_o  <= shadow[FR_W-1];
            shadow <= {shadow[FR_W-2:0], 1'b0};
            step   <= ONE;
          end else if (ma_rise) begin
            step <= step + ONE;
          end
        end
        ST_DATA: begin
          if (frame_end) begin
            st    <= ST_BUSY;
            slo_o <= 1'b0;
          end else if (ma_rise) begin
            slo_o  <= shadow[FR_W-1];
            shadow <= {shadow[FR_W-2:0], 1'b0};
            step   <= step + ONE;
          end
        end
        ST_BUSY: begin
          if (busy_hit) begin
            st    <= ST_IDLE;
            slo_o <= 1'b1;
          end
        end
        default: begin
          st    <= ST_IDLE;
          slo_o <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/enc_responder_chk.sv
module enc_responder_chk
  import enc_resp_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input resp_st_e st,
  input logic     slo_o,
  input logic     ack_go,
  input logic     ack_done,
  input logic     frame_end,
  input logic     abort,
  input logic     busy_hit
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> slo_o);                                  // R1
  AST_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ack_go |=> (!slo_o && st == ST_ACK));                        // R2
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done |=> (slo_o && st == ST_DATA));                      // R3
  AST_END_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (st == ST_BUSY));                              // R6
  AST_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY) |-> !slo_o);                                 // R6
  AST_ABORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (st == ST_BUSY && !slo_o));                        // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY && !busy_hit) |=> (st == ST_BUSY));           // R9
endmodule

bind enc_responder enc_responder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st        (st),
  .slo_o     (slo_o),
  .ack_go    (ack_go),
  .ack_done  (ack_done),
  .frame_end (frame_end),
  .abort     (abort),
  .busy_hit  (busy_hit)
);

// File: tb/test_enc_responder.sv
module test_enc_responder;
  localparam int POS_W    = 18;
  localparam int ACK_LEN  = 2;
  localparam int BUSY_CYC = 100;
  localparam int TOUT_CYC = 40;
  localparam int FR_W     = POS_W + 10;
  localparam int H        = 4;
  localparam int NV       = 6;

  // {pos, err_n, warn_n, pos applied after the request opens}
  localparam logic [2*POS_W+1:0] VEC [0:NV-1] = '{
    {18'h3FFFF, 1'b1, 1'b1, 18'h00000},
    {18'h00000, 1'b1, 1'b1, 18'h3FFFF},
    {18'h2A5C3, 1'b0, 1'b1, 18'h15A3C},
    {18'h15A3C, 1'b1, 1'b0, 18'h2A5C3},
    {18'h20001, 1'b0, 1'b0, 18'h1FFFE},
    {18'h1FFFE, 1'b1, 1'b1, 18'h20001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ma_i = 1'b1;
  logic [POS_W-1:0] pos_i = '0;
  logic err_n_i = 1'b1;
  logic warn_n_i = 1'b1;
  logic slo_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  enc_responder #(
    .POS_W(POS_W), .ACK_LEN(ACK_LEN), .BUSY_CYC(BUSY_CYC), .TOUT_CYC(TOUT_CYC)
  ) i_enc_responder (
    .clk(clk), .rst_n(rst_n), .ma_i(ma_i), .pos_i(pos_i),
    .err_n_i(err_n_i), .warn_n_i(warn_n_i), .slo_o(slo_o)
  );

  // remainder by long division, x^6 + x + 1
  function automatic logic [5:0] ref_crc(input logic [POS_W+1:0] msg);
    logic [POS_W+7:0] m;
    m = {msg, 6'b0};
    for (int i = POS_W + 7; i >= 6; i--) begin
      if (m[i]) m[i -: 7] = m[i -: 7] ^ 7'b1000011;
    end
    return m[5:0];
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: slo_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input logic [2*POS_W+1:0] v, input bit toggle);
    logic [FR_W-1:0] exp;
    logic [POS_W-1:0] p;
    p   = v[2*POS_W+1 -: POS_W];
    exp = {2'b10, v[2*POS_W+1:POS_W], ~ref_crc(v[2*POS_W+1:POS_W])};
    @(negedge clk);
    pos_i = p; err_n_i = v[POS_W+1]; warn_n_i = v[POS_W];
    ma_i = 1'b0;
    wait_cyc(H);
    for (int n = 1; n <= 1 + ACK_LEN + FR_W; n++) begin
      ma_i = 1'b1;
      wait_cyc(H);
      if (n == 1) begin   // R7: inputs move after the request opened
        pos_i = v[POS_W-1:0]; err_n_i = ~v[POS_W+1]; warn_n_i = ~v[POS_W];
      end
      ma_i = 1'b0;
      wait_cyc(H);
      if (n == 1) chk(slo_o, 1'b1, "R2 first edge");
      else if (n <= 1 + ACK_LEN) chk(slo_o, 1'b0, "R2 R3 acknowledge");
      else begin
        int k;
        k = n - 2 - ACK_LEN;
        if (k < 2) chk(slo_o, exp[FR_W-1-k], "R3 start/zero");
        else if (k < 2 + POS_W) chk(slo_o, exp[FR_W-1-k], "R4 R7 position");
        else if (k < 4 + POS_W) chk(slo_o, exp[FR_W-1-k], "R4 R7 error/warning");
        else chk(slo_o, exp[FR_W-1-k], "R5 checksum");
      end
    end
    ma_i = 1'b1;   // edge after the last checksum bit
    for (int i = 0; i < BUSY_CYC; i++) begin
      if (toggle) ma_i = (i >= 8 && i < BUSY_CYC - 20) ? (i[2] == 1'b1) : 1'b1;
      @(negedge clk);
    end
    chk(slo_o, 1'b0, toggle ? "R6 R9 busy low" : "R6 busy low");
    wait_cyc(12);
    chk(slo_o, 1'b1, "R6 ready again");
    if (toggle) begin
      wait_cyc(40);
      chk(slo_o, 1'b1, "R9 no request from busy edges");
    end
  endtask

  task automatic run_abort();
    @(negedge clk);
    ma_i = 1'b0;
    wait_cyc(H);
    for (int n = 1; n < 2 + ACK_LEN; n++) begin
      ma_i = 1'b1; wait_cyc(H);
      ma_i = 1'b0; wait_cyc(H);
    end
    ma_i = 1'b1;   // start bit goes out, then the master stops
    wait_cyc(TOUT_CYC - 4);
    chk(slo_o, 1'b1, "R8 start bit held before timeout");
    wait_cyc(12);
    chk(slo_o, 1'b0, "R8 busy after timeout");
    wait_cyc(BUSY_CYC + 4);
    chk(slo_o, 1'b1, "R8 ready after abort");
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_up();
  end

  initial begin
    wait_cyc(5);
    chk(slo_o, 1'b1, "R1 in reset");
    rst_n = 1'b1;
    wait_cyc(5);
    chk(slo_o, 1'b1, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      run_frame(VEC[i], (i == 3));
    end

    run_abort();
    run_frame(VEC[2], 1'b0);   // normal service after an abort

    finish_up();
  end
endmodule